// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is a two-wire (I2C-style) bus slave that exposes a byte-wide memory inside the chip. The memory is built from on-chip storage. A bus master reaches it with the usual bus conditions. A START condition opens a transfer. A control byte follows; it carries a fixed device code, three select bits and a direction bit. For writes, two address bytes come next. Data bytes follow, and a STOP condition closes the transfer. The slave has no SDA driver of its own. It asserts an output-enable that pulls the line low, and a pull-up on the board supplies the high level.

A single address pointer serves every access. Writes, random reads, sequential reads and reads with no address phase all use it. After each completed byte, read or written, the pointer steps forward by one. A read that starts without an address phase therefore continues from the byte after the last one touched. A write burst only steps the lowest three pointer bits, so it wraps inside its 8-byte page. A read burst steps the whole pointer and wraps from the top address to zero.

The SCL and SDA inputs are brought into the system clock domain and filtered for edges. Three strap inputs set the device-select value, so up to eight of these slaves can share one bus. The memory size is set by the address-width parameter. Address bits above that width are dropped.

Top module: `i2cm_slave`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The slave samples SDA on SCL high and changes its SDA enable only while SCL is low, so a bit it drives stays stable for the whole SCL high time.
- R2: The slave ACKs a control byte only if bits [7:4] equal 4'b1010 and bits [3:1] equal `dev_sel_i`. Any other control byte gets no ACK, and every later byte is ignored (no ACK) until the next START.
- R3: A write transfer is the control byte with bit 0 = 0, then the high address byte, then the low address byte, each ACKed by the slave. The address is {high, low}; bits at and above ADDR_W are ignored.
- R4: A data byte after the two address bytes is stored at the pointer and ACKed.
- R5: Within one write transfer, only pointer bits [2:0] step after each stored byte. Consecutive data bytes therefore wrap inside the 8-byte page, and the upper pointer bits are unchanged.
- R6: The pointer steps by one after each completed byte, read or written. A read control byte (bit 0 = 1) sent straight after START returns the byte at the last accessed address plus one.
- R7: A random read loads the address with a write header, follows it with a repeated START and a read control byte, and returns the byte at the loaded address.
- R8: In a read, a master ACK makes the slave send the next byte. The read pointer uses all ADDR_W bits and wraps from the top address to 0.
- R9: After a master NACK the slave leaves SDA released in the acknowledge slot and afterwards. After STOP its SDA enable is low.
- R10: A START or STOP arriving in the middle of a byte discards that byte without storing it. The pointer keeps the value it had after the last completed byte.
- R11: After reset the SDA enable is low and the bus line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; bus inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dev_sel_i | input | 3 | Strap value the control byte's select bits must match |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench goes after the page wrap: it writes four bytes from offset 6 of a page that was filled first. A design that carried into the upper pointer bits would spill two bytes into the next page and leave the start of this page stale. It reads across the top address. A page-style increment there would return the wrong second byte, and a missing wrap would read past the memory. It ends transfers in the middle of a byte with both STOP and START, then reads the current address. A design that stored the partial byte, or stepped the pointer early, would return the wrong value. Control bytes with a wrong select field or a wrong device code are sent as well. A slave that ACKed them, or that woke up on the bytes after them, would pull SDA low on a bus it does not own.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADRH,
    ST_ADRL,
    ST_WDAT,
    ST_RDAT
  } i2cm_state_e;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
  localparam int         BYTE_BITS = 8;

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_d     <= scl_s;
      sda_d     <= sda_s;
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // Bus conditions need SCL high on both sides of the SDA edge.
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2cm_ram.sv
module i2cm_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BITS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] dev_sel_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  typedef logic [ADDR_W-1:0] addr_t;

  logic        scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  i2cm_state_e st;
  addr_t       ptr;
  addr_t       page_next;
  logic [7:0]  shreg, hi_q, tx, rdata, wdata_q;
  logic [CNT_W-1:0] bitcnt;
  logic        in_ack, rw_q, mack_q, we_q, ctrl_hit;
  addr_t       waddr_q;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cm_ram #(.AW(ADDR_W), .DW(8)) ram_i (
    .clk   (clk),
    .we    (we_q),
    .waddr (waddr_q),
    .wdata (wdata_q),
    .raddr (ptr),
    .rdata (rdata)
  );

  assign ctrl_hit  = (shreg[7:4] == CTRL_CODE) && (shreg[3:1] == dev_sel_i);
  assign page_next = {ptr[ADDR_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + PAGE_BITS'(1)};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      shreg    <= '0;
      hi_q     <= '0;
      tx       <= '0;
      bitcnt   <= '0;
      in_ack   <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (start_det) begin
        st       <= ST_CTRL;
        bitcnt   <= '0;
        in_ack   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        bitcnt   <= '0;
        in_ack   <= 1'b0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st)
          ST_CTRL, ST_ADRH, ST_ADRL, ST_WDAT: begin
            if (!in_ack) begin
              if (scl_rise && bitcnt != CNT_FULL) begin
                shreg  <= {shreg[6:0], sda_s};
                bitcnt <= bitcnt + CNT_ONE;
              end else if (scl_fall && bitcnt == CNT_FULL) begin
                bitcnt <= '0;
                case (st)
                  ST_CTRL: begin
                    if (ctrl_hit) begin
                      in_ack   <= 1'b1;
                      sda_oe_o <= 1'b1;
                      rw_q     <= shreg[0];
                    end else begin
                      st <= ST_IDLE;
                    end
                  end
                  ST_ADRH: begin
                    hi_q     <= shreg;
                    in_ack   <= 1'b1;
                    sda_oe_o <= 1'b1;
                  end
                  ST_ADRL: begin
                    ptr      <= addr_t'({hi_q, shreg});
                    in_ack   <= 1'b1;
                    sda_oe_o <= 1'b1;
                  end
                  default: begin
                    we_q     <= 1'b1;
                    waddr_q  <= ptr;
                    wdata_q  <= shreg;
                    ptr      <= page_next;
                    in_ack   <= 1'b1;
                    sda_oe_o <= 1'b1;
                  end
                endcase
              end
            end else if (scl_fall) begin
              in_ack <= 1'b0;
              case (st)
                ST_CTRL: begin
                  if (rw_q) begin
                    st       <= ST_RDAT;
                    tx       <= rdata;
                    sda_oe_o <= ~rdata[7];
                    bitcnt   <= CNT_ONE;
                  end else begin
                    st       <= ST_ADRH;
                    sda_oe_o <= 1'b0;
                  end
                end
                ST_ADRH: begin
                  st       <= ST_ADRL;
                  sda_oe_o <= 1'b0;
                end
                ST_ADRL: begin
                  st       <= ST_WDAT;
                  sda_oe_o <= 1'b0;
                end
                default: sda_oe_o <= 1'b0;
              endcase
            end
          end
          ST_RDAT: begin
            if (!in_ack) begin
              if (scl_fall) begin
                if (bitcnt == CNT_FULL) begin
                  sda_oe_o <= 1'b0;
                  ptr      <= ptr + addr_t'(1);
                  in_ack   <= 1'b1;
                  bitcnt   <= '0;
                end else begin
                  tx       <= {tx[6:0], 1'b0};
                  sda_oe_o <= ~tx[6];
                  bitcnt   <= bitcnt + CNT_ONE;
                end
              end
            end else begin
              if (scl_rise) begin
                mack_q <= ~sda_s;
              end else if (scl_fall) begin
                in_ack <= 1'b0;
                if (mack_q) begin
                  tx       <= rdata;
                  sda_oe_o <= ~rdata[7];
                  bitcnt   <= CNT_ONE;
                end else begin
                  st       <= ST_IDLE;
                  sda_oe_o <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk
  import i2cm_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_BITS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input i2cm_state_e       st,
  input logic [ADDR_W-1:0] ptr
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s)); // R1

  AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WDAT && $past(st) == ST_WDAT)
      |-> ptr[ADDR_W-1:PAGE_BITS] == $past(ptr[ADDR_W-1:PAGE_BITS])); // R5

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe); // R9

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R9

  AST_PTR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> $past(scl_fall)); // R10

endmodule

bind i2cm_slave i2cm_slave_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe_o),
  .scl_s     (scl_s),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .st        (st),
  .ptr       (ptr)
);

// File: tb/i2cm_slave_tb_top.sv
module i2cm_slave_tb_top;

  localparam int AW = 11;
  localparam int Q  = 10;
  localparam logic [2:0] DEV = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic dut_oe;
  logic sda_line;
  int   nchk  = 0;
  int   nfail = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & ~dut_oe;

  i2cm_slave #(.ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .dev_sel_i (DEV),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe_o  (dut_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wq();
      m_scl = 1'b1; wq(); wq();
      m_scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    ack = ~sda_line;
    wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic send_chk(input string req, input logic [7:0] b, input bit exp_ack);
    bit a;
    send_byte(b, a);
    chk(req, a, exp_ack);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic s1;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_scl = 1'b1; wq();
      s1 = sda_line; wq();
      chk("R1 bit stable while SCL high", sda_line, s1);
      b[i] = s1;
      m_scl = 1'b0;
    end
    wq();
    chk("R9 slave released in ack slot", dut_oe, 0);
    m_sda = mack ? 1'b0 : 1'b1; wq();
    m_scl = 1'b1; wq(); wq();
    m_scl = 1'b0; wq();
    m_sda = 1'b1;
  endtask

  task automatic addr_phase(input logic [15:0] a);
    bus_start();
    send_chk("R3 write ctrl ack", {4'hA, DEV, 1'b0}, 1'b1);
    send_chk("R3 addr hi ack", a[15:8], 1'b1);
    send_chk("R3 addr lo ack", a[7:0], 1'b1);
  endtask

  task automatic byte_write(input logic [15:0] a, input logic [7:0] d);
    addr_phase(a);
    send_chk("R4 data ack", d, 1'b1);
    bus_stop();
  endtask

  task automatic rand_read1(input logic [15:0] a, output logic [7:0] d);
    addr_phase(a);
    bus_start();
    send_chk("R7 read ctrl ack", {4'hA, DEV, 1'b1}, 1'b1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic cur_read(output logic [7:0] d);
    bus_start();
    send_chk("R6 read ctrl ack", {4'hA, DEV, 1'b1}, 1'b1);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R11 sda enable after reset", dut_oe, 0);
    chk("R11 bus line after reset", sda_line, 1);
  endtask

  task automatic t_bad_ctrl();
    bus_start();
    send_chk("R2 wrong select no ack", {4'hA, 3'b010, 1'b0}, 1'b0);
    send_chk("R2 later byte ignored", 8'h00, 1'b0);
    bus_stop();
    bus_start();
    send_chk("R2 wrong code no ack", {4'hB, DEV, 1'b0}, 1'b0);
    bus_stop();
    chk("R9 released after stop", dut_oe, 0);
  endtask

  task automatic t_byte_write();
    logic [7:0] d;
    byte_write(16'h0123, 8'h3C);
    rand_read1(16'h0123, d);
    chk("R4 R7 random read data", d, 8'h3C);
  endtask

  task automatic t_high_addr();
    logic [7:0] d;
    byte_write(16'h0823, 8'h99);
    rand_read1(16'h0023, d);
    chk("R3 upper address bits ignored", d, 8'h99);
  endtask

  task automatic t_page();
    logic [7:0] d;
    logic [7:0] ev [8] = '{8'h33, 8'h44, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'h11, 8'h22};
    addr_phase(16'h0200);
    for (int i = 0; i < 8; i++) send_chk("R5 page byte ack", 8'hA0 + 8'(i), 1'b1);
    bus_stop();
    addr_phase(16'h0206);
    send_chk("R5 wrap byte ack", 8'h11, 1'b1);
    send_chk("R5 wrap byte ack", 8'h22, 1'b1);
    send_chk("R5 wrap byte ack", 8'h33, 1'b1);
    send_chk("R5 wrap byte ack", 8'h44, 1'b1);
    bus_stop();
    addr_phase(16'h0200);
    bus_start();
    send_chk("R8 read ctrl ack", {4'hA, DEV, 1'b1}, 1'b1);
    for (int i = 0; i < 8; i++) begin
      recv_byte(i != 7, d);
      chk("R5 R8 page content", d, ev[i]);
    end
    bus_stop();
  endtask

  task automatic t_current();
    logic [7:0] d;
    byte_write(16'h0301, 8'h88);
    byte_write(16'h0300, 8'h77);
    cur_read(d);
    chk("R6 current read after write", d, 8'h88);
    rand_read1(16'h0300, d);
    chk("R7 random read", d, 8'h77);
    cur_read(d);
    chk("R6 current read after read", d, 8'h88);
  endtask

  task automatic t_wrap();
    logic [7:0] d;
    byte_write(16'h07FF, 8'hE1);
    byte_write(16'h0000, 8'hE2);
    addr_phase(16'h07FF);
    bus_start();
    send_chk("R8 read ctrl ack", {4'hA, DEV, 1'b1}, 1'b1);
    recv_byte(1'b1, d);
    chk("R8 top address", d, 8'hE1);
    recv_byte(1'b0, d);
    chk("R8 wrap to zero", d, 8'hE2);
    bus_stop();
    chk("R9 released after nack stop", dut_oe, 0);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    byte_write(16'h0400, 8'h5A);
    addr_phase(16'h0400);
    send_bits(8'hFF, 4);
    bus_stop();
    cur_read(d);
    chk("R10 stop mid byte", d, 8'h5A);
    addr_phase(16'h0400);
    send_bits(8'h0F, 3);
    bus_start();
    send_chk("R10 read ctrl after restart", {4'hA, DEV, 1'b1}, 1'b1);
    recv_byte(1'b0, d);
    bus_stop();
    chk("R10 start mid byte", d, 8'h5A);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_ctrl();
    t_byte_write();
    t_high_addr();
    t_page();
    t_current();
    t_wrap();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL all: watchdog actual=timeout expected=finished");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule